// File: doc/BRIEF.md
# SCSI Initiator Controller Register File

This block is the host-facing register file of a small SCSI initiator controller. A host reaches sixteen byte registers over a simple byte bus. The register index is taken from the bus address after a configurable right shift. The block keeps two views of the registers. The read view is what the host reads back. The write view holds the last byte written to each index, and the whole write view is brought out for sibling blocks.

Bytes written to the command index are decoded. Chip reset, bus reset, FIFO flush, enable-selection and no-op are carried out inside the block. Transfer, response, message-accept, ATN and select commands go out as one-cycle pulses to the blocks that drive the SCSI bus. Those sibling blocks report their results back through an event-load port. An event load fills the status, interrupt and sequence-step registers and raises the interrupt. Reading the interrupt register is destructive: it acknowledges the interrupt and resets part of the status.

Top module: `scsi_regfile`

## Requirements
- R1: The register index is bus_addr shifted right by SHIFT (default 2), so index i sits at address i<<SHIFT, and the low SHIFT address bits are ignored.
- R2: After rst_n low, or one cycle after command opcode 0x02 is written, every read-view register and the whole write view are zero, with two exceptions. Index 8 reads 0x07 and index 0xE reads 0x04. irq, dma_mode and cmd_go are low.
- R3: Writes to indices 4, 5, 6, 7, 9 and 0xA update only the write view. Writes to indices 8 and 0xB to 0xF update both views. Writes to indices 0 and 1 update only the write view, so reading 0 or 1 still returns the old count.
- R4: A write to index 0 or 1 clears status bit 4 (index 4, the terminal-count flag).
- R5: A byte written to index 3 is read back at index 3. Its bit 7 drives dma_mode. When bit 7 is set, the read-view indices 0 and 1 are reloaded from their write-view bytes.
- R6: A read of index 5 returns the current interrupt code. On that clock edge, index 5 becomes 0, status bits 7 and 4 clear, and index 6 (the sequence step) becomes 4.
- R7: irq always equals status bit 7.
- R8: Opcode 0x03 (bus reset) loads index 5 with 0x80. It sets status bit 7 only when bit 6 of index 8 is clear.
- R9: Opcode 0x01 (flush) sets index 5 to 0x08 and clears indices 6 and 7. Opcode 0x44 (enable selection) clears index 5. Neither opcode changes irq.
- R10: One cycle after the command write, cmd_go pulses for exactly one cycle. Bit 0 is opcode 0x10, bit 1 is 0x11, bit 2 is 0x12, bit 3 is 0x1A, bit 4 is 0x42 and bit 5 is 0x43. Bit 7 of the command byte is ignored for this decode.
- R11: Opcode 0x00 and any opcode not listed change nothing except the command read-back and dma_mode (with its count reload).
- R12: A write to index 2 asserts fifo_push in the same cycle. A read of index 2 asserts fifo_pop and returns fifo_rdata.
- R13: ev_load sets status to {1, ev_stat}, index 5 to ev_intr and index 6 to ev_seq. A bus access in the same cycle wins for any field it also changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, same effect as a chip reset |
| bus_addr | input | SHIFT+4 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the current index |
| fifo_rdata | input | 8 | Byte supplied by the FIFO block for index 2 reads |
| fifo_push | output | 1 | FIFO write request |
| fifo_pop | output | 1 | FIFO read request |
| ev_load | input | 1 | Result load from sibling blocks |
| ev_stat | input | 7 | Status bits 6..0 to load |
| ev_intr | input | 8 | Interrupt code to load |
| ev_seq | input | 8 | Sequence step to load |
| cmd_go | output | 6 | One-hot command pulses |
| dma_mode | output | 1 | DMA flag of the last command |
| irq | output | 1 | Level interrupt |
| wr_view | output | 128 | Write view, index i at bits 8i+7..8i |

## Verification
A wrong status or interrupt state shows up at irq in the cycle after the access that caused it, and at bus_rdata on the next read of index 4 or 5. A wrong count reload stays hidden until the count registers are read back after a command with the DMA bit set. Faults in the write view appear on wr_view one cycle after the write. Every operation is followed by checks of irq, dma_mode, cmd_go and wr_view, so a divergence is caught within one bus operation.

// File: rtl/scsi_rf_pkg.sv
package scsi_rf_pkg;
   localparam int REG_N = 16;
   localparam int IDX_W = 4;
   localparam int GO_N  = 6;

   localparam logic [IDX_W-1:0] IX_CNT_LO = 4'h0;
   localparam logic [IDX_W-1:0] IX_CNT_MI = 4'h1;
   localparam logic [IDX_W-1:0] IX_FIFO   = 4'h2;
   localparam logic [IDX_W-1:0] IX_CMD    = 4'h3;
   localparam logic [IDX_W-1:0] IX_STAT   = 4'h4;
   localparam logic [IDX_W-1:0] IX_INT    = 4'h5;
   localparam logic [IDX_W-1:0] IX_SEQ    = 4'h6;
   localparam logic [IDX_W-1:0] IX_FLAGS  = 4'h7;
   localparam logic [IDX_W-1:0] IX_CFG_A  = 4'h8;
   localparam logic [IDX_W-1:0] IX_CFG_B  = 4'hB;
   localparam logic [IDX_W-1:0] IX_CFG_C  = 4'hC;
   localparam logic [IDX_W-1:0] IX_SPARE1 = 4'hD;
   localparam logic [IDX_W-1:0] IX_CNT_HI = 4'hE;
   localparam logic [IDX_W-1:0] IX_SPARE2 = 4'hF;

   localparam logic [7:0] CFG_A_RST   = 8'h07;
   localparam logic [7:0] CHIP_ID     = 8'h04;
   localparam logic [7:0] CODE_FDONE  = 8'h08;
   localparam logic [7:0] CODE_BRST   = 8'h80;
   localparam logic [7:0] SEQ_ACKED   = 8'h04;
   localparam int         ST_TC_BIT   = 4;
   localparam int         ST_IRQ_BIT  = 7;
   localparam int         CFG_MASK_BIT = 6;

   typedef struct packed {
      logic            flush;
      logic            chip_rst;
      logic            bus_rst;
      logic            ensel;
      logic [GO_N-1:0] go;
   } cmd_act_t;
endpackage

// File: rtl/scsi_rf_addr.sv
module scsi_rf_addr #(
   parameter int SHIFT = 2,
   localparam int ADDR_W = SHIFT + scsi_rf_pkg::IDX_W
) (
   input  logic [ADDR_W-1:0]              addr,
   output logic [scsi_rf_pkg::IDX_W-1:0]  idx
);
   generate
      if (SHIFT > 8) begin : g_bad
         $error("SHIFT must not exceed 8");
      end
      if (SHIFT == 0) begin : g_noshift
         assign idx = addr;
      end else begin : g_shift
         logic unused_lanes;
         assign unused_lanes = ^addr[SHIFT-1:0];
         assign idx = addr[ADDR_W-1:SHIFT];
      end
   endgenerate
endmodule

// File: rtl/scsi_rf_cmddec.sv
module scsi_rf_cmddec
   import scsi_rf_pkg::*;
(
   input  logic [6:0] opcode,
   output cmd_act_t   act
);
   always_comb begin
      act = '0;
      case (opcode)
         7'h01: act.flush    = 1'b1;
         7'h02: act.chip_rst = 1'b1;
         7'h03: act.bus_rst  = 1'b1;
         7'h44: act.ensel    = 1'b1;
         7'h10: act.go[0]    = 1'b1;
         7'h11: act.go[1]    = 1'b1;
         7'h12: act.go[2]    = 1'b1;
         7'h1A: act.go[3]    = 1'b1;
         7'h42: act.go[4]    = 1'b1;
         7'h43: act.go[5]    = 1'b1;
         default: act = '0;
      endcase
   end
endmodule

// File: rtl/scsi_regfile.sv
module scsi_regfile
   import scsi_rf_pkg::*;
#(
   parameter int SHIFT = 2,
   localparam int ADDR_W = SHIFT + IDX_W,
   localparam int VIEW_W = REG_N * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [7:0]        fifo_rdata,
   output logic              fifo_push,
   output logic              fifo_pop,
   input  logic              ev_load,
   input  logic [6:0]        ev_stat,
   input  logic [7:0]        ev_intr,
   input  logic [7:0]        ev_seq,
   output logic [GO_N-1:0]   cmd_go,
   output logic              dma_mode,
   output logic              irq,
   output logic [VIEW_W-1:0] wr_view
);
   logic [IDX_W-1:0] idx;
   cmd_act_t         act;
   logic             wr_cmd, chip_rst, int_ack;

   scsi_rf_addr #(.SHIFT(SHIFT)) u_addr (.addr(bus_addr), .idx(idx));
   scsi_rf_cmddec u_dec (.opcode(bus_wdata[6:0]), .act(act));

   assign wr_cmd   = bus_wr && (idx == IX_CMD);
   assign chip_rst = wr_cmd && act.chip_rst;
   assign int_ack  = bus_rd && !bus_wr && (idx == IX_INT);
   assign fifo_push = bus_wr && (idx == IX_FIFO);
   assign fifo_pop  = bus_rd && !bus_wr && (idx == IX_FIFO);

   // write view, one byte per index
   logic [7:0] wv_q [REG_N];
   for (genvar i = 0; i < REG_N; i++) begin : g_wview
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            wv_q[i] <= '0;
         else if (chip_rst)
            wv_q[i] <= '0;
         else if (bus_wr && (idx == IX_W'(i)))
            wv_q[i] <= bus_wdata;
      end
      assign wr_view[i*8 +: 8] = wv_q[i];
   end
   localparam int IX_W = IDX_W;

   // read view
   logic [7:0] cnt_lo_q, cnt_mi_q, cmd_q, stat_q, int_q, seq_q, flags_q;
   logic [7:0] cfg_a_q, cfg_b_q, cfg_c_q, sp1_q, cnt_hi_q, sp2_q;
   logic [GO_N-1:0] go_q;
   logic dma_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || chip_rst) begin
         // reset image shared by the pin and the command (R2)
         cnt_lo_q <= '0; cnt_mi_q <= '0; cmd_q <= '0; stat_q <= '0;
         int_q <= '0; seq_q <= '0; flags_q <= '0; cfg_a_q <= CFG_A_RST;
         cfg_b_q <= '0; cfg_c_q <= '0; sp1_q <= '0; cnt_hi_q <= CHIP_ID;
         sp2_q <= '0; go_q <= '0; dma_q <= 1'b0;
      end else begin
         go_q <= '0;
         if (ev_load) begin
            stat_q <= {1'b1, ev_stat};
            int_q  <= ev_intr;
            seq_q  <= ev_seq;
         end
         if (bus_wr) begin
            case (idx)
               IX_CNT_LO, IX_CNT_MI: stat_q[ST_TC_BIT] <= 1'b0;
               IX_CMD: begin
                  cmd_q <= bus_wdata;
                  dma_q <= bus_wdata[7];
                  if (bus_wdata[7]) begin
                     cnt_lo_q <= wv_q[IX_CNT_LO];
                     cnt_mi_q <= wv_q[IX_CNT_MI];
                  end
                  go_q <= act.go;
                  if (act.flush) begin
                     int_q <= CODE_FDONE; seq_q <= '0; flags_q <= '0;
                  end
                  if (act.bus_rst) begin
                     int_q <= CODE_BRST;
                     if (!cfg_a_q[CFG_MASK_BIT]) stat_q[ST_IRQ_BIT] <= 1'b1;
                  end
                  if (act.ensel) int_q <= '0;
               end
               IX_CFG_A:  cfg_a_q  <= bus_wdata;
               IX_CFG_B:  cfg_b_q  <= bus_wdata;
               IX_CFG_C:  cfg_c_q  <= bus_wdata;
               IX_SPARE1: sp1_q    <= bus_wdata;
               IX_CNT_HI: cnt_hi_q <= bus_wdata;
               IX_SPARE2: sp2_q    <= bus_wdata;
               default: ;
            endcase
         end else if (int_ack) begin
            int_q <= '0;
            seq_q <= SEQ_ACKED;
            stat_q[ST_TC_BIT]  <= 1'b0;
            stat_q[ST_IRQ_BIT] <= 1'b0;
         end
      end
   end

   always_comb begin
      case (idx)
         IX_CNT_LO: bus_rdata = cnt_lo_q;
         IX_CNT_MI: bus_rdata = cnt_mi_q;
         IX_FIFO:   bus_rdata = fifo_rdata;
         IX_CMD:    bus_rdata = cmd_q;
         IX_STAT:   bus_rdata = stat_q;
         IX_INT:    bus_rdata = int_q;
         IX_SEQ:    bus_rdata = seq_q;
         IX_FLAGS:  bus_rdata = flags_q;
         IX_CFG_A:  bus_rdata = cfg_a_q;
         IX_CFG_B:  bus_rdata = cfg_b_q;
         IX_CFG_C:  bus_rdata = cfg_c_q;
         IX_SPARE1: bus_rdata = sp1_q;
         IX_CNT_HI: bus_rdata = cnt_hi_q;
         IX_SPARE2: bus_rdata = sp2_q;
         default:   bus_rdata = 8'h00;
      endcase
   end

   assign cmd_go   = go_q;
   assign dma_mode = dma_q;
   assign irq      = stat_q[ST_IRQ_BIT];

   // R6
   int_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_ack |=> !irq && (seq_q == SEQ_ACKED) && (int_q == 8'h00));
   // R4
   cnt_wr_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && (idx == IX_CNT_LO || idx == IX_CNT_MI) |=> !stat_q[ST_TC_BIT]);
   // R10
   go_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd_go));
   // R10
   go_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmd && !act.chip_rst |=> cmd_go == $past(act.go));
   // R8
   brst_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cmd && act.bus_rst && cfg_a_q[CFG_MASK_BIT] && !irq && !ev_load |=> !irq);
   // R2
   chip_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chip_rst |=> !irq && !dma_mode && cfg_a_q == CFG_A_RST && cnt_hi_q == CHIP_ID);
endmodule

// File: tb/tb_scsi_regfile.sv
module tb_scsi_regfile;
   localparam int SHIFT = 2;
   localparam int AW = SHIFT + 4;

   logic clk = 0, rst_n = 0;
   logic [AW-1:0] bus_addr = '0;
   logic bus_wr = 0, bus_rd = 0, ev_load = 0;
   logic [7:0] bus_wdata = '0, fifo_rdata = 8'h5A, ev_intr = '0, ev_seq = '0;
   logic [6:0] ev_stat = '0;
   logic [7:0] bus_rdata;
   logic fifo_push, fifo_pop, dma_mode, irq;
   logic [5:0] cmd_go;
   logic [127:0] wr_view;

   scsi_regfile #(.SHIFT(SHIFT)) dut (.*);

   always #4 clk = ~clk;

   int total = 0, bad = 0;
   bit done = 0;
   logic [7:0] er [16];
   logic [7:0] ew [16];
   logic edma;
   logic [5:0] ego;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 16; i++) begin er[i] = 0; ew[i] = 0; end
      er[8] = 8'h07; er[14] = 8'h04; edma = 0; ego = 0;
   endtask

   task automatic check_outs(input string req);
      chk(irq == er[4][7], {req, " R7 irq"}, irq, er[4][7]);
      chk(dma_mode == edma, {req, " dma_mode"}, dma_mode, edma);
      chk(cmd_go == ego, {req, " R10 cmd_go"}, cmd_go, ego);
      for (int i = 0; i < 16; i++)
         chk(wr_view[i*8 +: 8] == ew[i], {req, " R3 wr_view"}, wr_view[i*8 +: 8], ew[i]);
   endtask

   task automatic wr(input int ix, input logic [7:0] v, input string req);
      @(negedge clk);
      bus_addr = AW'(ix << SHIFT) | AW'(ix & 3); // low lane bits ignored (R1)
      bus_wdata = v; bus_wr = 1;
      #1 chk(fifo_push == (ix == 2), "R12 push", fifo_push, ix == 2);
      @(negedge clk);
      bus_wr = 0;
      ew[ix] = v; ego = 0;
      case (ix)
         0, 1: er[4][4] = 0;
         3: begin
            er[3] = v; edma = v[7];
            if (v[7]) begin er[0] = ew[0]; er[1] = ew[1]; end
            case (v[6:0])
               7'h01: begin er[5] = 8'h08; er[6] = 0; er[7] = 0; end
               7'h02: model_reset();
               7'h03: begin er[5] = 8'h80; if (!er[8][6]) er[4][7] = 1; end
               7'h44: er[5] = 0;
               7'h10: ego = 6'b000001;
               7'h11: ego = 6'b000010;
               7'h12: ego = 6'b000100;
               7'h1A: ego = 6'b001000;
               7'h42: ego = 6'b010000;
               7'h43: ego = 6'b100000;
               default: ;
            endcase
         end
         8, 11, 12, 13, 14, 15: er[ix] = v;
         default: ;
      endcase
      check_outs(req);
   endtask

   task automatic rd(input int ix, input string req);
      logic [7:0] exp;
      @(negedge clk);
      bus_addr = AW'(ix << SHIFT); bus_rd = 1;
      exp = (ix == 2) ? fifo_rdata : er[ix];
      #1 chk(bus_rdata == exp, req, bus_rdata, exp);
      chk(fifo_pop == (ix == 2), "R12 pop", fifo_pop, ix == 2);
      @(negedge clk);
      bus_rd = 0; ego = 0;
      if (ix == 5) begin er[5] = 0; er[6] = 8'h04; er[4][7] = 0; er[4][4] = 0; end
      check_outs(req);
   endtask

   task automatic ev(input logic [6:0] s, input logic [7:0] i, input logic [7:0] q);
      @(negedge clk);
      ev_load = 1; ev_stat = s; ev_intr = i; ev_seq = q;
      @(negedge clk);
      ev_load = 0; ego = 0;
      er[4] = {1'b1, s}; er[5] = i; er[6] = q;
      check_outs("R13 event");
   endtask

   task automatic sweep(input string req);
      for (int i = 0; i < 16; i++) if (i != 5) rd(i, req);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] ops [12];
      ops = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h10, 8'h11, 8'h12, 8'h1A, 8'h42, 8'h43, 8'h44, 8'h27};
      void'($urandom(32'h00C0FFEE));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check_outs("R2 reset");
      sweep("R2 reset values");
      // R3 / R5: count write does not reach read view until DMA command
      wr(0, 8'h34, "R3 cnt lo"); wr(1, 8'h12, "R3 cnt mid");
      rd(0, "R3 count read unchanged"); rd(1, "R3 count read unchanged");
      wr(3, 8'h00, "R5 nop no reload"); rd(0, "R5 no reload");
      wr(3, 8'h80, "R5 dma reload"); rd(0, "R5 reload lo"); rd(1, "R5 reload mid");
      // R4 / R6
      ev(7'h13, 8'h18, 8'h02);
      wr(1, 8'h01, "R4 tc clear"); rd(4, "R4 status");
      ev(7'h10, 8'h18, 8'h02);
      rd(5, "R6 int old value"); rd(5, "R6 int cleared"); rd(6, "R6 seq 4"); rd(4, "R6 status");
      // R8 masked and unmasked
      wr(8, 8'h47, "R8 mask on"); wr(3, 8'h03, "R8 masked"); rd(5, "R8 code");
      wr(8, 8'h07, "R8 mask off"); wr(3, 8'h03, "R8 raised"); rd(4, "R8 status");
      // R9
      ev(7'h00, 8'h55, 8'h03); wr(3, 8'h01, "R9 flush"); sweep("R9 after flush");
      wr(3, 8'h44, "R9 ensel"); rd(5, "R9 ensel int");
      // R11 unknown
      wr(3, 8'h7F, "R11 unknown"); sweep("R11 unknown");
      // R10 pulses
      for (int k = 4; k < 10; k++) wr(3, ops[k] | 8'h80, "R10 pulse");
      // R2 chip reset command
      wr(14, 8'hAA, "R3 hi"); wr(3, 8'h82, "R2 chip reset"); sweep("R2 after chip reset");
      // constrained random
      for (int n = 0; n < 600; n++) begin
         int r; r = $urandom % 10;
         if (r < 4) begin
            int ix; ix = $urandom % 16;
            if (ix == 3) wr(3, ops[$urandom % 12] | 8'(($urandom % 2) << 7), "R10 R11 random cmd");
            else wr(ix, 8'($urandom), "R3 random write");
         end else if (r < 9) begin
            fifo_rdata = 8'($urandom);
            rd($urandom % 16, "R1 random read");
         end else ev(7'($urandom), 8'($urandom), 8'($urandom));
      end
      // external reset mid-run
      wr(8, 8'h33, "R3 cfg"); ev(7'h11, 8'h10, 8'h01);
      @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
      model_reset(); @(negedge clk);
      check_outs("R2 pin reset"); sweep("R2 pin reset");
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule